// File: doc/BRIEF.md
# PHY Event Interrupt Controller

This block collects seven status events from an Ethernet PHY and drives a single active-low interrupt line. Each source level is brought into the clock domain through a synchroniser. Its set edge latches a sticky flag. The interrupt line goes low while any flag is pending and its enable bit is set. Each source has its own set edge and its own clear conditions. The clear conditions are a falling source edge, a read of the flag register, reads of two other status registers, a restart of auto-negotiation, and a falling edge of link status.

Software reaches the enable register, the flag register and a mode-select bit through a simple register port. The port has an address, read and write strobes, and 16-bit data. Reads of status registers that other blocks serve arrive on the same port. The block decodes those reads only to clear flags, and returns zero for them. The mode bit is stored and read back but has no effect: only the primary clearing behaviour is built.

Top module: `phy_irq_ctrl`

## Requirements
- R1: `irq_n` is registered. It is 1 during and after reset. One cycle after any flag is 1 with its enable bit set, `irq_n` is 0. Otherwise it is 1.
- R2: Register 30 holds the enable bits and register 29 holds the flags, both in bits 7..1. The bit order is: 7 energy-on, 6 negotiation complete, 5 remote fault, 4 link down, 3 partner acknowledge, 2 parallel-detect fault, 1 page received. On a read, `rd_data` is valid in the cycle after the strobe. It is zero in cycles with no read, and it is zero for unserved addresses. Unused bits read 0. Writes to them, and any write to register 29, have no effect.
- R3: The mode bit is bit 6 of register 17. It resets to 0, reads back what was written, and does not change flag or interrupt behaviour.
- R4: Each `src` bit passes through two synchroniser flops and then an edge detector. A flag is set on the third rising clock edge after its input changes. Link down is set by a falling edge of `src[3]`. Every other flag is set by a rising edge of its input. `src[k]` maps to flag bit k+1.
- R5: A read of register 29 returns the flags as they were before the read, then clears every flag.
- R6: The energy-on, negotiation-complete and partner-acknowledge flags clear on a falling edge of their input.
- R7: The remote-fault flag clears on a falling edge of its input or on a read of register 1. The link-down flag clears on a read of register 1.
- R8: The parallel-detect-fault and page-received flags clear on any of these: a falling edge of their input, a read of register 6, an `aneg_restart` pulse, or a falling edge of `src[3]`.
- R9: If a set edge and a clear condition for a flag occur in the same cycle, the flag ends up set.
- R10: All enable bits reset to 0. A flag latches whether or not its enable bit is set, and a disabled flag does not pull `irq_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | 7 | Asynchronous source levels; bit k feeds flag bit k+1, bit 3 is link status |
| aneg_restart | input | 1 | One-cycle pulse: auto-negotiation restarted |
| reg_addr | input | 5 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| irq_n | output | 1 | Active-low interrupt |

## Verification
A change on `src` shows up in a flag at the third clock edge after it is driven. It shows up on `irq_n` at the fourth edge. Register read data, and the flag clear caused by a read, both appear one edge after the strobe. The interrupt line follows that clear one edge later. The reference model in the bench keeps the last three source samples and recomputes the expected `irq_n` and `rd_data` on every clock. It compares them at the falling edge, away from the edges where the design registers update. Directed checks wait exactly those edge counts before they sample.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int NSRC    = 7;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int FLAG_LSB = 1;
  localparam int MODE_BIT = 6;

  // source indices; index k lands in register bit k+FLAG_LSB
  localparam int S_PAGE   = 0;
  localparam int S_PDF    = 1;
  localparam int S_ACK    = 2;
  localparam int S_LINK   = 3;
  localparam int S_RFAULT = 4;
  localparam int S_ANDONE = 5;
  localparam int S_ENERGY = 6;

  localparam logic [ADDR_W-1:0] A_STATUS = 5'd1;
  localparam logic [ADDR_W-1:0] A_ANEXP  = 5'd6;
  localparam logic [ADDR_W-1:0] A_MODE   = 5'd17;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 5'd29;
  localparam logic [ADDR_W-1:0] A_ENABLE = 5'd30;
endpackage

// File: rtl/phy_irq_sync.sv
module phy_irq_sync #(
  parameter int N      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [DEPTH-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[DEPTH-2:0], din[g]};
    end
    assign rise[g] =  sh[STAGES-1] & ~sh[STAGES];
    assign fall[g] = ~sh[STAGES-1] &  sh[STAGES];
  end
endmodule

// File: rtl/phy_irq_flags.sv
module phy_irq_flags
  import phy_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] rise,
  input  logic [N-1:0] fall,
  input  logic         rd_flags,
  input  logic         rd_status,
  input  logic         rd_anexp,
  input  logic         aneg_restart,
  output logic [N-1:0] flags
);
  logic [N-1:0] set_v;
  logic [N-1:0] clr_v;
  logic         nego_clr;

  assign nego_clr = rd_anexp | aneg_restart | fall[S_LINK];

  always_comb begin
    set_v         = rise;
    set_v[S_LINK] = fall[S_LINK];

    clr_v           = '0;
    clr_v[S_ENERGY] = fall[S_ENERGY];
    clr_v[S_ANDONE] = fall[S_ANDONE];
    clr_v[S_ACK]    = fall[S_ACK];
    clr_v[S_RFAULT] = fall[S_RFAULT] | rd_status;
    clr_v[S_LINK]   = rd_status;
    clr_v[S_PDF]    = fall[S_PDF]  | nego_clr;
    clr_v[S_PAGE]   = fall[S_PAGE] | nego_clr;
    if (rd_flags) clr_v = '1;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= set_v | (flags & ~clr_v);
  end

  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_flags && set_v == '0) |=> (flags == '0));
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_v) |=> ((flags & $past(set_v)) == $past(set_v)));
  a_r6_energy_fall: assert property (@(posedge clk) disable iff (rst)
    fall[S_ENERGY] |=> !flags[S_ENERGY]);
  a_r7_status_read: assert property (@(posedge clk) disable iff (rst)
    (rd_status && !fall[S_LINK] && !rise[S_RFAULT]) |=> (!flags[S_LINK] && !flags[S_RFAULT]));
endmodule

// File: rtl/phy_irq_regs.sv
module phy_irq_regs
  import phy_irq_pkg::*;
#(
  parameter int N = NSRC,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  flags,
  output logic [N-1:0]  enable,
  output logic          mode,
  output logic [DW-1:0] rdata,
  output logic          rd_flags,
  output logic          rd_status,
  output logic          rd_anexp
);
  logic unused_wbits;
  assign unused_wbits = ^{wdata[DW-1:FLAG_LSB+N], wdata[FLAG_LSB-1:0]};

  assign rd_flags  = rd && (addr == A_FLAGS);
  assign rd_status = rd && (addr == A_STATUS);
  assign rd_anexp  = rd && (addr == A_ANEXP);

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= '0;
      mode   <= 1'b0;
      rdata  <= '0;
    end else begin
      if (wr && addr == A_ENABLE) enable <= wdata[FLAG_LSB +: N];
      if (wr && addr == A_MODE)   mode   <= wdata[MODE_BIT];
      rdata <= '0;
      if (rd) begin
        case (addr)
          A_FLAGS:  rdata[FLAG_LSB +: N] <= flags;
          A_ENABLE: rdata[FLAG_LSB +: N] <= enable;
          A_MODE:   rdata[MODE_BIT]      <= mode;
          default:  ;
        endcase
      end
    end
  end

  a_r10_enable_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (enable == '0));
  a_r3_mode_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mode == 1'b0));
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !$past(rd) |-> (rdata == '0));
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
  import phy_irq_pkg::*;
#(
  parameter int N      = NSRC,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      src,
  input  logic              aneg_restart,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  logic [N-1:0] rise, fall, flags, enable;
  logic         mode;
  logic         rd_flags, rd_status, rd_anexp;

  phy_irq_sync #(.N(N), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(src), .rise(rise), .fall(fall)
  );

  phy_irq_flags #(.N(N)) u_flags (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall),
    .rd_flags(rd_flags), .rd_status(rd_status), .rd_anexp(rd_anexp),
    .aneg_restart(aneg_restart), .flags(flags)
  );

  phy_irq_regs #(.N(N), .AW(ADDR_W), .DW(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .addr(reg_addr), .rd(reg_rd), .wr(reg_wr),
    .wdata(reg_wdata), .flags(flags), .enable(enable), .mode(mode),
    .rdata(rd_data), .rd_flags(rd_flags), .rd_status(rd_status),
    .rd_anexp(rd_anexp)
  );

  logic unused_mode;
  assign unused_mode = mode;

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|(flags & enable);
  end

  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (enable == '0) |=> irq_n);
  a_r10_no_flags_quiet: assert property (@(posedge clk) disable iff (rst)
    (flags == '0) |=> irq_n);
endmodule

// File: tb/phy_irq_ctrl_tb.sv
module phy_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  src = '0;
  logic        aneg_restart = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rd_data;
  logic        irq_n;

  int vectors = 0;
  int miscompares = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .src(src), .aneg_restart(aneg_restart),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .irq_n(irq_n)
  );

  // behavioural reference
  logic [6:0] hist[$] = '{7'h0, 7'h0, 7'h0};
  logic [6:0] m_flags = '0, m_en = '0;
  logic       m_mode = 1'b0;
  logic       e_irq_n = 1'b1;
  logic [15:0] e_rdata = '0;

  always @(posedge clk) begin
    if (rst) begin
      hist = '{7'h0, 7'h0, 7'h0};
      m_flags = '0; m_en = '0; m_mode = 1'b0;
      e_irq_n = 1'b1; e_rdata = '0;
    end else begin
      logic [6:0] up, dn, setm, clrm;
      e_irq_n = ((m_flags & m_en) == 0);
      e_rdata = '0;
      if (reg_rd) begin
        if (reg_addr == 29) e_rdata = {8'h0, m_flags, 1'b0};
        else if (reg_addr == 30) e_rdata = {8'h0, m_en, 1'b0};
        else if (reg_addr == 17) e_rdata = {9'h0, m_mode, 6'h0};
      end
      up = hist[1] & ~hist[0];
      dn = ~hist[1] & hist[0];
      setm = up; setm[3] = dn[3];
      clrm = '0;
      clrm[6] = dn[6]; clrm[5] = dn[5]; clrm[2] = dn[2];
      clrm[4] = dn[4] | (reg_rd && reg_addr == 1);
      clrm[3] = reg_rd && reg_addr == 1;
      for (int k = 0; k < 2; k++)
        clrm[k] = dn[k] | (reg_rd && reg_addr == 6) | aneg_restart | dn[3];
      if (reg_rd && reg_addr == 29) clrm = '1;
      m_flags = setm | (m_flags & ~clrm);
      if (reg_wr && reg_addr == 30) m_en = reg_wdata[7:1];
      if (reg_wr && reg_addr == 17) m_mode = reg_wdata[6];
      void'(hist.pop_front());
      hist.push_back(src);
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      vectors++;
      if (irq_n !== e_irq_n) begin
        miscompares++;
        $display("FAIL R1 model irq_n: actual %b expected %b at %0t", irq_n, e_irq_n, $time);
      end
      vectors++;
      if (rd_data !== e_rdata) begin
        miscompares++;
        $display("FAIL R2 model rd_data: actual %h expected %h at %0t", rd_data, e_rdata, $time);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [15:0] v);
    reg_addr = a; reg_rd = 1'b1;
    tick(1);
    reg_rd = 1'b0;
    v = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    tick(3);
    rst = 1'b0;
    cmp_on = 1'b1;
    tick(1);
    chk("R1 reset irq_n", {15'h0, irq_n}, 16'h1);
    rd_reg(30, v); chk("R10 enable reset", v, 16'h0000);

    wr_reg(30, 16'hFFFF);
    rd_reg(30, v); chk("R2 enable unused bits", v, 16'h00FE);
    wr_reg(17, 16'hFFFF);
    rd_reg(17, v); chk("R3 mode readback", v, 16'h0040);
    rd_reg(5, v);  chk("R2 unserved address", v, 16'h0000);
    wr_reg(29, 16'hFFFF);
    rd_reg(29, v); chk("R2 flag write ignored", v, 16'h0000);

    src[6] = 1'b1; tick(4);
    chk("R4 energy rise", {15'h0, irq_n}, 16'h0);
    src[6] = 1'b0; tick(4);
    chk("R6 energy fall clear", {15'h0, irq_n}, 16'h1);

    src[3] = 1'b1; tick(5);
    rd_reg(29, v); chk("R4 link rise sets nothing", v, 16'h0000);
    src[3] = 1'b0; tick(4);
    chk("R4 link fall", {15'h0, irq_n}, 16'h0);
    rd_reg(1, v); tick(1);
    chk("R7 status read clears link", {15'h0, irq_n}, 16'h1);

    src[4] = 1'b1; tick(4);
    rd_reg(29, v); chk("R5 pre-clear value", v, 16'h0020);
    tick(1);
    chk("R5 irq after read", {15'h0, irq_n}, 16'h1);
    rd_reg(29, v); chk("R5 flags cleared", v, 16'h0000);
    src[4] = 1'b0; tick(4);
    src[4] = 1'b1; tick(4);
    chk("R4 remote fault set", {15'h0, irq_n}, 16'h0);
    src[4] = 1'b0; tick(4);
    chk("R7 remote fault fall", {15'h0, irq_n}, 16'h1);

    src[0] = 1'b1; tick(4);
    chk("R4 page set", {15'h0, irq_n}, 16'h0);
    aneg_restart = 1'b1; tick(1); aneg_restart = 1'b0; tick(1);
    chk("R8 restart clears page", {15'h0, irq_n}, 16'h1);
    src[1] = 1'b1; tick(4);
    chk("R4 pdf set", {15'h0, irq_n}, 16'h0);
    rd_reg(6, v); tick(1);
    chk("R8 reg6 read clears pdf", {15'h0, irq_n}, 16'h1);
    src[0] = 1'b0; tick(4);
    src[0] = 1'b1; tick(4);
    src[3] = 1'b1; tick(4);
    chk("R4 link rise keeps irq", {15'h0, irq_n}, 16'h0);
    src[3] = 1'b0; tick(3);
    rd_reg(29, v); chk("R8 link down clears page", v, 16'h0010);

    src[0] = 1'b0; tick(4);
    src[0] = 1'b1; tick(2);
    rd_reg(29, v); chk("R9 read at set edge", v, 16'h0000);
    rd_reg(29, v); chk("R9 set wins", v, 16'h0002);

    wr_reg(30, 16'h0000);
    src[2] = 1'b1; tick(4);
    chk("R10 disabled quiet", {15'h0, irq_n}, 16'h1);
    rd_reg(29, v); chk("R10 disabled flag latched", v, 16'h0008);

    wr_reg(30, 16'h00FE);
    src[2] = 1'b0; tick(4);
    src[2] = 1'b1; tick(4);
    chk("R4 ack set", {15'h0, irq_n}, 16'h0);
    src[2] = 1'b0; tick(4);
    chk("R6 ack fall clear", {15'h0, irq_n}, 16'h1);
    src[5] = 1'b1; tick(4);
    chk("R4 andone set", {15'h0, irq_n}, 16'h0);
    src[5] = 1'b0; tick(4);
    chk("R6 andone fall clear", {15'h0, irq_n}, 16'h1);

    wr_reg(17, 16'h0000);
    rd_reg(17, v); chk("R3 mode cleared", v, 16'h0000);

    tick(5);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule